// File: doc/BRIEF.md
# Evicted-Tag Demand Monitor

This block belongs to one core and estimates how much that core would gain from more cache capacity. It keeps a small first-in first-out buffer of the tags of blocks recently evicted for that core. When a later access misses in the cache, the block looks up the missing tag in that buffer. A match means a slightly larger cache would have turned that miss into a hit. The block counts these matches, and it also counts every cache access the core makes.

Software outside the block divides matches by accesses to get a gain figure per core. An interval strobe closes each measurement window. The strobe usually comes from a retired-instruction counter, every ten million instructions or so. On the strobe, both counts are copied into snapshot registers and the live counters restart. A two-state controller tracks the window. `ST_COUNT` is the normal accumulating state. `ST_PUBLISH` lasts one cycle after each strobe, and its output `snap_vld` announces fresh snapshot values. The transitions are:
- COUNT→PUBLISH on a strobe.
- PUBLISH→PUBLISH on a back-to-back strobe.
- PUBLISH→COUNT otherwise.

Top module: `evtag_demand_mon`

## Requirements
- R1: After reset, `snap_vld` is 0, both snapshots read 0, both live counts are 0 and every buffer slot is empty, so no lookup can match until a tag has been written.
- R2: Each cycle with `acc_vld`=1 adds one to the access count, whether or not `acc_miss` is set.
- R3: The buffer is looked up only when `acc_vld`=1 and `acc_miss`=1. An access with `acc_miss`=0 adds no match and leaves the buffer unchanged.
- R4: A missing access whose tag equals a valid buffer entry adds exactly one to the match count.
- R5: A matched entry is invalidated, so a second miss on the same tag does not match again unless the tag is evicted once more.
- R6: Evictions fill the `DEPTH` slots in arrival order. Eviction number `DEPTH`+1 overwrites the oldest tag, and the other tags stay.
- R7: A lookup sees the buffer as it was before the eviction written in the same cycle. A miss on a tag evicted in that same cycle does not match, but a miss on it one cycle later does.
- R8: On a cycle with `ivl_end`=1, the snapshots take the counts accumulated in earlier cycles. `snap_vld` is 1 in the next cycle. Events in the strobe cycle itself are counted in the new window.
- R9: Both counts saturate at 2^`CNT_W`-1 instead of wrapping.
- R10: Between strobes, the snapshots hold their values and `snap_vld` stays 0 after its one-cycle pulse.
- R11: Within a window the match count never exceeds the access count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_vld | input | 1 | A block of this core is evicted this cycle |
| evict_tag | input | TAG_W | Tag of the evicted block |
| acc_vld | input | 1 | The core makes a cache access this cycle |
| acc_miss | input | 1 | The access missed in the cache |
| acc_tag | input | TAG_W | Tag of the access |
| ivl_end | input | 1 | End-of-interval strobe |
| snap_vld | output | 1 | One-cycle pulse: snapshots were just updated |
| snap_hits | output | CNT_W | Buffer matches counted in the closed window |
| snap_accs | output | CNT_W | Accesses counted in the closed window |

## Verification
Each count update takes effect at the clock edge that samples the access. A strobe driven in the following cycle therefore captures that update. The new snapshot and `snap_vld` appear right after the strobe edge. The bench drives every input just after a rising edge and holds it for exactly one edge. It reads the snapshot one time unit after the strobe edge, and it reads hold behaviour several edges later. This makes each check land in the first cycle its result is due. The same-cycle eviction case and the strobe-cycle access case are driven together on one edge, so ordering is decided by the design and not by the bench.

// File: rtl/evtag_pkg.sv
package evtag_pkg;

    typedef enum logic [0:0] {
        ST_COUNT   = 1'b0,
        ST_PUBLISH = 1'b1
    } ivl_state_e;

endpackage

// File: rtl/evtag_buffer.sv
module evtag_buffer #(
    parameter int TAG_W = 20,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             lk_en,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;
    logic [IDX_W-1:0] wr_ptr_q;

    // Per-slot compare and update; a write to a slot beats its invalidation
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
            end else if (wr_en && (wr_ptr_q == IDX_W'(g))) begin
                vld_q[g] <= 1'b1;
                tag_q[g] <= wr_tag;
            end else if (lk_en && match[g]) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    assign lk_hit = lk_en && (|match);

    // Oldest-slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (wr_en) begin
            wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/evtag_sat_counter.sv
module evtag_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= W'(inc);
        end else if (inc && (cnt != MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/evtag_ivl_ctrl.sv
module evtag_ivl_ctrl
    import evtag_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ivl_end,
    input  logic [CNT_W-1:0] hit_cnt,
    input  logic [CNT_W-1:0] acc_cnt,
    output logic             snap_vld,
    output logic [CNT_W-1:0] snap_hits,
    output logic [CNT_W-1:0] snap_accs
);
    ivl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT:   state_d = ivl_end ? ST_PUBLISH : ST_COUNT;
            ST_PUBLISH: state_d = ivl_end ? ST_PUBLISH : ST_COUNT;
            default:    state_d = ST_COUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    // Outputs: snapshot capture on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hits <= '0;
            snap_accs <= '0;
        end else if (ivl_end) begin
            snap_hits <= hit_cnt;
            snap_accs <= acc_cnt;
        end
    end

    assign snap_vld = (state_q == ST_PUBLISH);

endmodule

// File: rtl/evtag_demand_mon.sv
module evtag_demand_mon #(
    parameter int TAG_W = 20,
    parameter int DEPTH = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_vld,
    input  logic [TAG_W-1:0] evict_tag,
    input  logic             acc_vld,
    input  logic             acc_miss,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic             ivl_end,
    output logic             snap_vld,
    output logic [CNT_W-1:0] snap_hits,
    output logic [CNT_W-1:0] snap_accs
);
    logic             lookup_en;
    logic             lookup_hit;
    logic [CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0] acc_cnt;

    assign lookup_en = acc_vld && acc_miss;

    evtag_buffer #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (evict_vld),
        .wr_tag (evict_tag),
        .lk_en  (lookup_en),
        .lk_tag (acc_tag),
        .lk_hit (lookup_hit)
    );

    evtag_sat_counter #(.W(CNT_W)) u_hit_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ivl_end),
        .inc     (lookup_hit),
        .cnt     (hit_cnt)
    );

    evtag_sat_counter #(.W(CNT_W)) u_acc_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ivl_end),
        .inc     (acc_vld),
        .cnt     (acc_cnt)
    );

    evtag_ivl_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ivl_end   (ivl_end),
        .hit_cnt   (hit_cnt),
        .acc_cnt   (acc_cnt),
        .snap_vld  (snap_vld),
        .snap_hits (snap_hits),
        .snap_accs (snap_accs)
    );

endmodule

// File: rtl/evtag_demand_mon_chk.sv
module evtag_demand_mon_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_vld,
    input logic             acc_miss,
    input logic             ivl_end,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] acc_cnt,
    input logic             snap_vld,
    input logic [CNT_W-1:0] snap_hits,
    input logic [CNT_W-1:0] snap_accs
);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    p_pulse_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_end |=> snap_vld);

    p_pulse_only_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_end |=> !snap_vld);

    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_end |=> ($stable(snap_hits) && $stable(snap_accs)));

    p_access_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !ivl_end && acc_cnt != MAX) |=> (acc_cnt == $past(acc_cnt) + 1'b1));

    p_no_lookup_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc_vld && acc_miss) && !ivl_end) |=> (hit_cnt == $past(hit_cnt)));

    p_acc_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == MAX && !ivl_end) |=> (acc_cnt == MAX));

    p_hit_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cnt == MAX && !ivl_end) |=> (hit_cnt == MAX));

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_end && !acc_vld) |=> (acc_cnt == '0 && hit_cnt == '0));

    p_hits_bounded_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= acc_cnt);

endmodule

bind evtag_demand_mon evtag_demand_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_vld   (acc_vld),
    .acc_miss  (acc_miss),
    .ivl_end   (ivl_end),
    .hit_cnt   (hit_cnt),
    .acc_cnt   (acc_cnt),
    .snap_vld  (snap_vld),
    .snap_hits (snap_hits),
    .snap_accs (snap_accs)
);

// File: tb/tb_evtag_demand_mon.sv
`timescale 1ns/1ps
module tb_evtag_demand_mon;
    localparam int TAG_W = 20;
    localparam int DEPTH = 32;
    localparam int CNT_W = 16;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             evict_vld = 1'b0;
    logic [TAG_W-1:0] evict_tag = '0;
    logic             acc_vld = 1'b0;
    logic             acc_miss = 1'b0;
    logic [TAG_W-1:0] acc_tag = '0;
    logic             ivl_end = 1'b0;
    logic             snap_vld;
    logic [CNT_W-1:0] snap_hits;
    logic [CNT_W-1:0] snap_accs;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evtag_demand_mon #(.TAG_W(TAG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .evict_vld(evict_vld), .evict_tag(evict_tag),
        .acc_vld(acc_vld), .acc_miss(acc_miss), .acc_tag(acc_tag),
        .ivl_end(ivl_end), .snap_vld(snap_vld), .snap_hits(snap_hits),
        .snap_accs(snap_accs)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All stimulus tasks start and end 1 ns after a rising edge
    task automatic evict(input logic [TAG_W-1:0] t);
        evict_vld = 1'b1; evict_tag = t;
        @(posedge clk); #1;
        evict_vld = 1'b0;
    endtask

    task automatic access(input logic [TAG_W-1:0] t, input logic miss);
        acc_vld = 1'b1; acc_miss = miss; acc_tag = t;
        @(posedge clk); #1;
        acc_vld = 1'b0; acc_miss = 1'b0;
    endtask

    task automatic strobe_check(string req, int exp_hits, int exp_accs);
        ivl_end = 1'b1;
        @(posedge clk); #1;
        ivl_end = 1'b0;
        check({req, " snap_vld"}, int'(snap_vld), 1);
        check({req, " hits"}, int'(snap_hits), exp_hits);
        check({req, " accs"}, int'(snap_accs), exp_accs);
    endtask

    task automatic t_reset();
        check("R1 snap_vld", int'(snap_vld), 0);
        check("R1 snap_hits", int'(snap_hits), 0);
        check("R1 snap_accs", int'(snap_accs), 0);
        access('0, 1'b1);                      // empty buffer: tag 0 must not match
        strobe_check("R1 empty buffer", 0, 1);
    endtask

    task automatic t_basic();
        evict(20'h11); evict(20'h22);
        access(20'h11, 1'b1);                  // R4 match
        access(20'h22, 1'b0);                  // R3 cache hit, no lookup
        access(20'h33, 1'b1);                  // miss, not in buffer
        strobe_check("R2 R4 mixed", 1, 3);
        access(20'h22, 1'b1);                  // R3 entry survived the hit access
        access(20'h11, 1'b1);                  // R5 entry was invalidated
        strobe_check("R3 R5 reuse", 1, 2);
    endtask

    task automatic t_same_cycle();
        evict_vld = 1'b1; evict_tag = 20'h44;
        acc_vld = 1'b1; acc_miss = 1'b1; acc_tag = 20'h44;
        @(posedge clk); #1;
        evict_vld = 1'b0; acc_vld = 1'b0; acc_miss = 1'b0;
        access(20'h44, 1'b1);
        strobe_check("R7 same-cycle evict", 1, 2);
    endtask

    task automatic t_fifo();
        for (int i = 0; i <= DEPTH; i++) evict(TAG_W'(20'h100 + i));
        access(20'h100, 1'b1);                 // oldest overwritten
        access(20'h101, 1'b1);                 // still held
        strobe_check("R6 fifo overwrite", 1, 2);
    endtask

    task automatic t_strobe_edge();
        acc_vld = 1'b1; acc_miss = 1'b0; ivl_end = 1'b1;
        @(posedge clk); #1;
        acc_vld = 1'b0; ivl_end = 1'b0;
        check("R8 strobe-cycle access excluded", int'(snap_accs), 0);
        access(20'h5, 1'b0); access(20'h6, 1'b1);
        @(posedge clk); #1;
        check("R10 pulse ends", int'(snap_vld), 0);
        check("R10 hold accs", int'(snap_accs), 0);
        strobe_check("R8 strobe-cycle access in new window", 0, 3);
    endtask

    task automatic t_saturate();
        acc_vld = 1'b1; acc_miss = 1'b0;
        repeat (MAXC + 5) @(posedge clk);
        #1 acc_vld = 1'b0;
        strobe_check("R9 saturation", 0, MAXC);
        strobe_check("R9 restart after saturation", 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_same_cycle();
        t_fifo();
        t_strobe_edge();
        t_saturate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule